// File: doc/BRIEF.md
# Sleep and Wake Control Register

This block is an 8-bit control register for a small microcontroller. It sits on a simple single-cycle bus and controls four things:

- whether two port pins drive open-drain or push-pull;
- whether the watchdog is enabled;
- whether the oscillator runs;
- whether two resistor-option pins may be sensed.

A configuration option input can force the watchdog off, whatever the register holds.

The sleep-control bit governs the oscillator. Software clears the bit to stop the oscillator and enter sleep. An external active-low wake-up line sets the bit again, and this restarts the oscillator. The line is honoured only while the wake-up enable bit allows it, and it is first passed through a two-flop synchronizer. A software write of 1 to the bit also wakes the device.

Every 0-to-1 change of the bit loads a start-up timer, and the same happens at reset. While the timer is nonzero, the CPU stall output is held, so the CPU resumes only after a parameterised number of cycles. The register is clocked from an always-running clock, so that the wake logic stays alive while the main oscillator is stopped.

Top module: `sleep_wake_ctl`

## Requirements
- R1: After reset the register reads 0x10: sleep control (bit 4) is 1 and all other bits are 0. The stall output stays high for exactly STARTUP clock edges after reset is released, then falls.
- R2: Bits 6, 5, 4, 3 and 0 are written from the bus write data when sel and wr are high. Bits 7, 2 and 1 always read 0 and ignore writes, so a write of 0xFF reads back as 0x79.
- R3: od_en follows bit 6 (open-drain enable), and opt_en follows bit 3 (resistor-option sense enable).
- R4: wdt_en equals bit 5 while cfg_wdt_off is 0, and is 0 whenever cfg_wdt_off is 1.
- R5: A write with bit 4 = 0 clears sleep control at that edge: osc_en goes low and stall goes high.
- R6: With bit 0 = 0, a low level on wake_n sets bit 4 on the third rising edge after it appears, and osc_en goes high at that edge.
- R7: With bit 0 = 1, a low level on wake_n has no effect, and the device stays asleep.
- R8: From the edge where bit 4 goes from 0 to 1, through a wake or a software write, stall stays high for exactly STARTUP edges and then falls.
- R9: If a software write clearing bit 4 and a synchronized wake request fall in the same cycle, bit 4 stays 1, and the timer does not restart.
- R10: stall is high whenever bit 4 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register select |
| wr | input | 1 | Write strobe, qualified by sel |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Register read data |
| wake_n | input | 1 | Asynchronous active-low wake-up line |
| cfg_wdt_off | input | 1 | Configuration option; 1 forces the watchdog off |
| od_en | output | 1 | Open-drain enable for two port pins |
| opt_en | output | 1 | Resistor-option sense enable |
| wdt_en | output | 1 | Effective watchdog enable |
| osc_en | output | 1 | Oscillator run enable |
| stall | output | 1 | CPU stall (asleep or start-up timer running) |

## Verification
Two functions can act on bit 4 in the same cycle: the hardware wake set and a software clear.

The bench provokes this by holding wake_n low for two edges, so that the synchronized request is live, and then issuing a write of 0x00 in the very cycle where the request acts. It judges the outcome on the next read. Bit 4 must still read 1, osc_en must stay high, and stall must stay low, which shows the timer did not reload.

Once wake_n has been released and the synchronizer has drained, the same write must then put the device to sleep.

// File: rtl/sleep_wake_ctl.sv
module sleep_wake_ctl #(
  parameter int STARTUP = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       wake_n,
  input  logic       cfg_wdt_off,
  output logic       od_en,
  output logic       opt_en,
  output logic       wdt_en,
  output logic       osc_en,
  output logic       stall
);
  localparam int CW = $clog2(STARTUP + 1);
  localparam logic [CW-1:0] LOAD = CW'(STARTUP);

  logic          od_q, wdt_q, slp_q, opt_q, wkdis_q;
  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic          we, wake_hit, slp_nxt;

  assign we       = sel & wr;
  assign wake_hit = ~s2 & ~wkdis_q;
  assign slp_nxt  = wake_hit ? 1'b1 : (we ? wdata[4] : slp_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= wake_n;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      od_q    <= 1'b0;
      wdt_q   <= 1'b0;
      opt_q   <= 1'b0;
      wkdis_q <= 1'b0;
      slp_q   <= 1'b1;
    end else begin
      if (we) begin
        od_q    <= wdata[6];
        wdt_q   <= wdata[5];
        opt_q   <= wdata[3];
        wkdis_q <= wdata[0];
      end
      slp_q <= slp_nxt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cnt <= LOAD;
    else if (slp_nxt && !slp_q)
      cnt <= LOAD;
    else if (slp_q && cnt != '0)
      cnt <= cnt - 1'b1;

  assign rdata  = {1'b0, od_q, wdt_q, slp_q, opt_q, 2'b00, wkdis_q};
  assign od_en  = od_q;
  assign opt_en = opt_q;
  assign wdt_en = wdt_q & ~cfg_wdt_off;
  assign osc_en = slp_q;
  assign stall  = ~slp_q | (cnt != '0);

  a_r4_wdt_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wdt_off |-> !wdt_en);

  a_r6_wake_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> osc_en);

  a_r5_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wdata[4] && !wake_hit) |=> !osc_en);

  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slp_q) |-> (cnt == LOAD && stall));

  a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_q && cnt != '0 && !we && !wake_hit) |=> (cnt == $past(cnt) - CW'(1)));

  a_r10_sleep_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> stall);

  a_r9_wake_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && we && !wdata[4]) |=> (osc_en && $stable(cnt == LOAD) || cnt != LOAD));
endmodule

// File: tb/sim_sleep_wake_ctl.sv
module sim_sleep_wake_ctl;
  localparam int STARTUP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic wake_n = 1'b1, cfg_wdt_off = 1'b0;
  logic od_en, opt_en, wdt_en, osc_en, stall;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sleep_wake_ctl #(.STARTUP(STARTUP)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .wdata(wdata), .rdata(rdata),
    .wake_n(wake_n), .cfg_wdt_off(cfg_wdt_off), .od_en(od_en), .opt_en(opt_en),
    .wdt_en(wdt_en), .osc_en(osc_en), .stall(stall)
  );

  // {wdata, cfg, exp_rdata, exp_od, exp_wdt, exp_opt}
  localparam logic [19:0] VEC [7] = '{
    {8'h10, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0},
    {8'hFF, 1'b0, 8'h79, 1'b1, 1'b1, 1'b1},
    {8'hFF, 1'b1, 8'h79, 1'b1, 1'b0, 1'b1},
    {8'h50, 1'b0, 8'h50, 1'b1, 1'b0, 1'b0},
    {8'h38, 1'b0, 8'h38, 1'b0, 1'b1, 1'b1},
    {8'hB6, 1'b1, 8'h30, 1'b0, 1'b0, 1'b0},
    {8'h11, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [7:0] d);
    sel = 1'b1; wr = 1'b1; wdata = d;
    tick(1);
    sel = 1'b0; wr = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    check("R1 reset rdata", rdata, 8'h10);
    check("R1 reset stall", stall, 1'b1);
    tick(STARTUP - 1);
    check("R1 stall before end", stall, 1'b1);
    tick(1);
    check("R1 stall released", stall, 1'b0);

    for (int i = 0; i < 7; i++) begin
      cfg_wdt_off = VEC[i][11];
      wreg(VEC[i][19:12]);
      check("R2 rdata", rdata, VEC[i][10:3]);
      check("R3 od_en", od_en, VEC[i][2]);
      check("R4 wdt_en", wdt_en, VEC[i][1]);
      check("R3 opt_en", opt_en, VEC[i][0]);
    end
    cfg_wdt_off = 1'b0;
    wreg(8'h10);

    wreg(8'h00);
    check("R5 osc_en off", osc_en, 1'b0);
    check("R10 stall asleep", stall, 1'b1);
    tick(3);
    check("R10 still asleep", stall, 1'b1);

    wake_n = 1'b0;
    tick(2);
    check("R6 not yet awake", osc_en, 1'b0);
    tick(1);
    check("R6 awake", osc_en, 1'b1);
    check("R6 rdata", rdata, 8'h10);
    check("R8 stall at wake", stall, 1'b1);
    wake_n = 1'b1;
    tick(STARTUP - 1);
    check("R8 stall before end", stall, 1'b1);
    tick(1);
    check("R8 stall released", stall, 1'b0);

    wreg(8'h01);
    wake_n = 1'b0;
    tick(6);
    check("R7 blocked wake", osc_en, 1'b0);
    check("R7 rdata", rdata, 8'h01);
    wake_n = 1'b1;
    tick(3);
    wreg(8'h10);
    check("R8 sw wake osc", osc_en, 1'b1);
    tick(STARTUP - 1);
    check("R8 sw wake stall", stall, 1'b1);
    tick(1);
    check("R8 sw wake release", stall, 1'b0);

    wake_n = 1'b0;
    tick(2);
    wreg(8'h00);
    check("R9 set wins rdata", rdata, 8'h10);
    check("R9 osc stays", osc_en, 1'b1);
    check("R9 no reload", stall, 1'b0);
    wake_n = 1'b1;
    tick(3);
    wreg(8'h00);
    check("R5 clear after drain", osc_en, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule